// File: doc/BRIEF.md
# Serial Frame Transmitter with Selectable Interrupt Point

This block turns bytes written by a host into asynchronous serial frames on a single output line. A byte written into a one-deep holding register moves into a shift stage when the line is free. The block sends a low start bit, then 7 or 8 data bits starting with the least significant bit. An optional parity bit follows. The frame ends with high stop bits: one stop bit when parity is on, two when it is off. A rate tick from an external divider paces the line, and every bit occupies sixteen of those ticks. The line rests high between frames.

A small control register holds the settings: transmit enable, interrupt enable, interrupt mode, word length, parity enable and parity sense. The interrupt can be raised at one of two points. One is as soon as the holding register has room again (end of byte). The other is only once the holding register and the shift stage are both empty (end of message). Software writes the next byte while the current one is on the line, and frames then follow each other with no gap.

The sequencer is a named state machine. IDLE goes to START on LOAD when the transmitter is enabled and a byte is held. START goes to DATA at the end of a bit. DATA loops once per data bit, then goes to PARITY if parity is on, or to STOP1 if it is off. PARITY goes to STOP1. STOP1 goes to IDLE when parity is on, or to STOP2 when it is off. STOP2 goes to IDLE. From the final stop bit the machine goes straight back to START (CHAIN) when a further byte is waiting and the transmitter is enabled.

Top module: `sertx_top`

## Requirements
- R1: After reset the line is high, the holding register reads empty (`hold_empty_o`=1), the interrupt is low and the control register is all zero.
- R2: Each transmitted bit lasts exactly sixteen cycles in which `tick_i` is high. Cycles without a tick do not advance the frame.
- R3: A frame starts with one low start bit, followed by the data least significant bit first. Eight data bits are sent when control bit 3 is 1, and seven (bits 0 to 6) when it is 0.
- R4: When control bit 4 is 1, a parity bit follows the data and one high stop bit follows the parity bit. Control bit 5 set to 1 gives odd parity (data plus parity ones count is odd); set to 0 it gives even parity.
- R5: When control bit 4 is 0, two high stop bits follow the data.
- R6: A data write while the holding register is empty stores the byte and drives `hold_empty_o` to 0 from the next cycle. A data write while the holding register is full is ignored, and the held byte is the one that is later sent.
- R7: A held byte moves into the shift stage on the cycle after the shift stage is idle, or at the edge that ends the last stop bit. Consecutive frames then follow with no idle bit time, and `hold_empty_o` returns to 1 at that transfer.
- R8: With control bit 0 (enable) at 0, no new frame begins and a held byte stays held. A frame already in progress completes.
- R9: `irq_o` equals control bit 1 ANDed with a condition. With control bit 2 at 0, the condition is holding register empty. With control bit 2 at 1, the condition is holding register empty and the shift stage idle.
- R10: Word length and parity settings are captured when a frame starts. Control writes during a frame affect only later frames.
- R11: The line is high whenever no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Rate tick, sixteen per bit |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 6 | Control value: bit0 enable, bit1 irq enable, bit2 irq mode, bit3 eight-bit word, bit4 parity enable, bit5 odd parity |
| dat_we_i | input | 1 | Data write strobe into the holding register |
| dat_wdata_i | input | 8 | Data byte to send |
| txd_o | output | 1 | Serial line |
| irq_o | output | 1 | Interrupt request |
| hold_empty_o | output | 1 | Holding register empty status |

## Verification
The assertions check, on every cycle, several properties of the line and the controls:
- the line stays high in IDLE and both stop states, and low in START;
- the sixteen-tick bit counter holds still on cycles without a tick;
- a disabled transmitter never leaves IDLE;
- a write into a full holding register leaves the held byte alone;
- the interrupt is masked by its enable, and in end-of-message mode it stays low while a frame is running.

The bench's reference model is needed for the rest:
- the exact bit order, length and parity of whole frames;
- frames chained with no gap;
- settings captured at frame start while the control register changes mid-frame;
- the precise cycle at which the interrupt and status change.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    // Control register field positions
    localparam int CTL_W     = 6;
    localparam int CB_EN     = 0;
    localparam int CB_IEN    = 1;
    localparam int CB_IMODE  = 2;
    localparam int CB_LEN8   = 3;
    localparam int CB_PEN    = 4;
    localparam int CB_PODD   = 5;

    typedef struct packed {
        logic podd;
        logic pen;
        logic len8;
        logic imode;
        logic ien;
        logic en;
    } tx_ctl_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP1 = 3'd4,
        ST_STOP2 = 3'd5
    } tx_state_e;

    function automatic tx_ctl_t unpack_ctl(input logic [CTL_W-1:0] v);
        tx_ctl_t c;
        c.en    = v[CB_EN];
        c.ien   = v[CB_IEN];
        c.imode = v[CB_IMODE];
        c.len8  = v[CB_LEN8];
        c.pen   = v[CB_PEN];
        c.podd  = v[CB_PODD];
        return c;
    endfunction

endpackage

// File: rtl/sertx_ctl.sv
module sertx_ctl
    import sertx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [CTL_W-1:0] wdata_i,
    output tx_ctl_t          ctl_o
);

    logic [CTL_W-1:0] ctl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (we_i) begin
            ctl_q <= wdata_i;
        end
    end

    always_comb begin
        ctl_o = unpack_ctl(ctl_q);
    end

endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              take_i,
    output logic [DATA_W-1:0] data_o,
    output logic              empty_o
);

    logic [DATA_W-1:0] data_q;
    logic              empty_q;

    // take_i only ever asserts while the register is full, so a write
    // arriving on that cycle is dropped like any other write to a full register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            empty_q <= 1'b1;
        end else if (take_i) begin
            empty_q <= 1'b1;
        end else if (we_i && empty_q) begin
            data_q  <= wdata_i;
            empty_q <= 1'b0;
        end
    end

    assign data_o  = data_q;
    assign empty_o = empty_q;

endmodule

// File: rtl/sertx_baud.sv
module sertx_baud #(
    parameter int TICKS = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick_i,
    input  logic                     run_i,
    input  logic                     restart_i,
    output logic [$clog2(TICKS)-1:0] cnt_o,
    output logic                     bit_end_o
);

    localparam int CW = $clog2(TICKS);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= '0;
        end else if (run_i && tick_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign bit_end_o = run_i && tick_i && (cnt_q == LAST);
    assign cnt_o     = cnt_q;

endmodule

// File: rtl/sertx_fsm.sv
module sertx_fsm
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tx_ctl_t           ctl_i,
    input  logic              hold_empty_i,
    input  logic [DATA_W-1:0] hold_data_i,
    input  logic              bit_end_i,
    output logic              take_o,
    output tx_state_e         state_o,
    output logic              txd_o
);

    localparam int IW = $clog2(DATA_W);
    localparam logic [IW-1:0] IDX_LONG  = IW'(DATA_W - 1);
    localparam logic [IW-1:0] IDX_SHORT = IW'(DATA_W - 2);

    tx_state_e         state_q, state_d;
    logic [DATA_W-1:0] shreg_q;
    logic [IW-1:0]     idx_q;
    logic              len8_q;
    logic              pen_q;
    logic              par_q;
    logic              last_data;
    logic              last_stop;
    logic              take;
    logic              par_calc;
    logic [DATA_W-1:0] masked;

    // Parity over the active word length only
    always_comb begin
        masked = hold_data_i;
        if (!ctl_i.len8) begin
            masked[DATA_W-1] = 1'b0;
        end
        par_calc = (^masked) ^ ctl_i.podd;
    end

    assign last_data = (idx_q == (len8_q ? IDX_LONG : IDX_SHORT));
    assign last_stop = (state_q == ST_STOP2) || ((state_q == ST_STOP1) && pen_q);
    assign take = ctl_i.en && !hold_empty_i &&
                  ((state_q == ST_IDLE) || (bit_end_i && last_stop));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take) state_d = ST_START;
            end
            ST_START: begin
                if (bit_end_i) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (bit_end_i && last_data) state_d = pen_q ? ST_PAR : ST_STOP1;
            end
            ST_PAR: begin
                if (bit_end_i) state_d = ST_STOP1;
            end
            ST_STOP1: begin
                if (bit_end_i) begin
                    if (take)       state_d = ST_START;
                    else if (pen_q) state_d = ST_IDLE;
                    else            state_d = ST_STOP2;
                end
            end
            ST_STOP2: begin
                if (bit_end_i) state_d = take ? ST_START : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Shift stage and per-frame settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            idx_q   <= '0;
            len8_q  <= 1'b0;
            pen_q   <= 1'b0;
            par_q   <= 1'b0;
        end else if (take) begin
            shreg_q <= hold_data_i;
            idx_q   <= '0;
            len8_q  <= ctl_i.len8;
            pen_q   <= ctl_i.pen;
            par_q   <= par_calc;
        end else if ((state_q == ST_DATA) && bit_end_i) begin
            shreg_q <= shreg_q >> 1;
            idx_q   <= idx_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_START: txd_o = 1'b0;
            ST_DATA:  txd_o = shreg_q[0];
            ST_PAR:   txd_o = par_q;
            default:  txd_o = 1'b1;
        endcase
    end

    assign take_o  = take;
    assign state_o = state_q;

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int TICKS  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              ctl_we_i,
    input  logic [5:0]        ctl_wdata_i,
    input  logic              dat_we_i,
    input  logic [DATA_W-1:0] dat_wdata_i,
    output logic              txd_o,
    output logic              irq_o,
    output logic              hold_empty_o
);

    localparam int CW = $clog2(TICKS);

    tx_ctl_t           ctl;
    logic [DATA_W-1:0] hold_data;
    logic              hold_empty;
    logic              take;
    logic              bit_end;
    logic [CW-1:0]     tick_cnt;
    tx_state_e         fsm_state;
    logic              shift_idle;

    sertx_ctl u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (ctl_we_i),
        .wdata_i (ctl_wdata_i),
        .ctl_o   (ctl)
    );

    sertx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (dat_we_i),
        .wdata_i (dat_wdata_i),
        .take_i  (take),
        .data_o  (hold_data),
        .empty_o (hold_empty)
    );

    sertx_baud #(.TICKS(TICKS)) u_baud (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .run_i     (!shift_idle),
        .restart_i (take),
        .cnt_o     (tick_cnt),
        .bit_end_o (bit_end)
    );

    sertx_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_i        (ctl),
        .hold_empty_i (hold_empty),
        .hold_data_i  (hold_data),
        .bit_end_i    (bit_end),
        .take_o       (take),
        .state_o      (fsm_state),
        .txd_o        (txd_o)
    );

    assign shift_idle = (fsm_state == ST_IDLE);

    always_comb begin
        irq_o = ctl.ien && hold_empty && (!ctl.imode || shift_idle);
    end

    assign hold_empty_o = hold_empty;

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int TICKS  = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     tick_i,
    input logic                     dat_we_i,
    input logic                     txd_o,
    input logic                     irq_o,
    input logic                     hold_empty_o,
    input tx_state_e                fsm_state,
    input logic [$clog2(TICKS)-1:0] tick_cnt,
    input logic [DATA_W-1:0]        hold_data,
    input logic                     take,
    input tx_ctl_t                  ctl
);

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE) |-> txd_o);                                    // R11

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_START) |-> !txd_o);                                  // R3

    AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_STOP1 || fsm_state == ST_STOP2) |-> txd_o);          // R5

    AST_NO_TICK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && fsm_state != ST_IDLE) |=> $stable(tick_cnt));             // R2

    AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_empty_o && dat_we_i && !take) |=> ($stable(hold_data) && !hold_empty_o)); // R6

    AST_DISABLED_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE && !ctl.en) |=> (fsm_state == ST_IDLE));        // R8

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.ien |-> !irq_o);                                                 // R9

    AST_IRQ_MSG_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.imode && fsm_state != ST_IDLE) |-> !irq_o);                      // R9

endmodule

bind sertx_top sertx_chk #(.DATA_W(DATA_W), .TICKS(TICKS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .dat_we_i     (dat_we_i),
    .txd_o        (txd_o),
    .irq_o        (irq_o),
    .hold_empty_o (hold_empty_o),
    .fsm_state    (fsm_state),
    .tick_cnt     (tick_cnt),
    .hold_data    (hold_data),
    .take         (take),
    .ctl          (ctl)
);

// File: tb/sertx_tb.sv
module sertx_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       ctl_we_i = 1'b0;
    logic [5:0] ctl_wdata_i = '0;
    logic       dat_we_i = 1'b0;
    logic [7:0] dat_wdata_i = '0;
    logic       txd_o, irq_o, hold_empty_o;

    int checks = 0;
    int errors = 0;
    int tick_div = 1;
    bit finished = 0;

    always #10 clk = ~clk;

    sertx_top dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .ctl_we_i(ctl_we_i), .ctl_wdata_i(ctl_wdata_i),
        .dat_we_i(dat_we_i), .dat_wdata_i(dat_wdata_i),
        .txd_o(txd_o), .irq_o(irq_o), .hold_empty_o(hold_empty_o)
    );

    // Reference model state
    bit       m_line[$];
    bit       m_busy;
    int       m_tk;
    bit       m_full;
    bit [7:0] m_hold;
    bit [5:0] m_ctl;

    function automatic void build_frame(bit [7:0] d, bit [5:0] c);
        int n;
        int ones;
        n = c[3] ? 8 : 7;
        ones = 0;
        m_line.delete();
        m_line.push_back(1'b0);
        for (int i = 0; i < n; i++) begin
            m_line.push_back(d[i]);
            ones += d[i];
        end
        if (c[4]) begin
            // odd: total ones odd; even: total ones even
            m_line.push_back(c[5] ? ((ones % 2) == 0) : ((ones % 2) == 1));
            m_line.push_back(1'b1);
        end else begin
            m_line.push_back(1'b1);
            m_line.push_back(1'b1);
        end
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_line.delete();
            m_busy = 0; m_tk = 0; m_full = 0; m_hold = 0; m_ctl = 0;
        end else begin
            if (m_busy && tick_i) begin
                if (m_tk == 15) begin
                    m_tk = 0;
                    void'(m_line.pop_front());
                    if (m_line.size() == 0) m_busy = 0;
                end else begin
                    m_tk++;
                end
            end
            if (!m_busy && m_ctl[0] && m_full) begin
                build_frame(m_hold, m_ctl);
                m_busy = 1; m_tk = 0; m_full = 0;
            end else if (dat_we_i && !m_full) begin
                m_hold = dat_wdata_i; m_full = 1;
            end
            if (ctl_we_i) m_ctl = ctl_wdata_i;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit et, ei;
            et = m_busy ? m_line[0] : 1'b1;
            ei = m_ctl[1] && !m_full && (!m_ctl[2] || !m_busy);
            chk(txd_o == et, "R3/R4/R5/R7/R10/R11 txd", txd_o, et);
            chk(hold_empty_o == !m_full, "R6/R7 hold_empty", hold_empty_o, !m_full);
            chk(irq_o == ei, "R9 irq", irq_o, ei);
        end
    end

    // Rate tick generator
    initial begin
        int tc;
        tc = 0;
        forever begin
            @(negedge clk);
            tc++;
            tick_i = ((tc % tick_div) == 0);
        end
    end

    task automatic wr_ctl(input bit [5:0] v);
        @(negedge clk); ctl_we_i = 1; ctl_wdata_i = v;
        @(negedge clk); ctl_we_i = 0;
    endtask

    task automatic wr_dat(input bit [7:0] v);
        @(negedge clk); dat_we_i = 1; dat_wdata_i = v;
        @(negedge clk); dat_we_i = 0;
    endtask

    task automatic wait_hold_empty();
        do @(negedge clk); while (m_full);
    endtask

    task automatic wait_all_done();
        do @(negedge clk); while (m_full || m_busy);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int low_run;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(txd_o == 1, "R1 txd", txd_o, 1);
        chk(hold_empty_o == 1, "R1 hold_empty", hold_empty_o, 1);
        chk(irq_o == 0, "R1 irq", irq_o, 0);

        // R2: start bit length with a tick every cycle, 8N2, end-of-byte irq
        tick_div = 1;
        wr_ctl(6'b001011);
        wr_dat(8'hA5);
        while (txd_o) @(negedge clk);
        low_run = 0;
        while (!txd_o) begin low_run++; @(negedge clk); end
        chk(low_run == 16, "R2 start bit cycles", low_run, 16);
        // R7 chained frame, then R6 write into full register is dropped
        wr_dat(8'h3C);
        wr_dat(8'hFF);
        chk(hold_empty_o == 0, "R6 still full", hold_empty_o, 0);
        wait_all_done();

        // R4 even parity, 8 bits, slow ticks
        tick_div = 3;
        wr_ctl(6'b011011);
        wr_dat(8'h37);
        wr_dat(8'h80);
        wait_all_done();

        // R4 odd parity, 7 bits, end-of-message irq (R9)
        wr_ctl(6'b110111);
        wr_dat(8'hD5);
        wait_hold_empty();
        wr_dat(8'h02);
        wait_all_done();

        // R5 seven bits, no parity, two stops
        tick_div = 2;
        wr_ctl(6'b000011);
        wr_dat(8'h7E);
        wait_all_done();

        // R8 disabled: byte stays held, line idle
        wr_ctl(6'b001010);
        wr_dat(8'h5A);
        repeat (60) @(negedge clk);
        chk(txd_o == 1, "R8 line idle while disabled", txd_o, 1);
        chk(hold_empty_o == 0, "R8 byte held while disabled", hold_empty_o, 0);
        wr_ctl(6'b001011);
        wait_all_done();

        // R10 settings change mid-frame; R8 disable mid-frame completes frame
        wr_ctl(6'b001011);
        wr_dat(8'hC3);
        repeat (40) @(negedge clk);
        wr_ctl(6'b110111);
        wr_dat(8'h19);
        repeat (30) @(negedge clk);
        wr_ctl(6'b110110);
        repeat (800) @(negedge clk);
        chk(hold_empty_o == 0, "R8 second byte held after disable", hold_empty_o, 0);
        wr_ctl(6'b110111);
        wait_all_done();

        // R9 irq disabled
        wr_ctl(6'b001001);
        wr_dat(8'h11);
        wait_all_done();
        chk(irq_o == 0, "R9 masked irq", irq_o, 0);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule